// File: doc/BRIEF.md
# Dual-Target Flash Configuration Loader

This block copies two configuration images out of a parallel flash with a 16-bit data bus into two target devices that accept configuration one byte at a time. The flash region starting at byte address 0x0002_0000 goes to target 0, and the region starting at 0x020A_0000 goes to target 1. Each region is a fixed parameter pair of first byte and last byte. The loader produces the flash word address and an active-low read strobe. It also drives a configuration clock, an 8-bit configuration data bus and one active-low configuration request per target. It watches a status input and a done input from each target.

A pass starts by itself when reset is released, or later on a start request while the loader is idle. An active-low strap gates the whole loader, and a per-target active-low enable picks which targets take part. The pass handles target 0 first and then target 1. For each one it pulses the request, waits for status to go high, and streams every flash word of the image as two bytes. It then waits for the target's done input.

If a target drops its status during streaming, that load is abandoned and a per-target error flag is raised. If the next fetch would fall inside the protected option region, the load is likewise abandoned with the error flag raised. In both cases the pass moves on to the next target. A single done output is raised at the end of a pass in which no target failed.

Top module: `dual_cfg_loader`

## Requirements
- R1: Following reset release with `enStrapN` low, a pass begins without any start request. While idle, a one-cycle `startReq` pulse begins a new pass. During reset `cfgReqN` is 2'b11, `flashRdN` is 1, `cfgClk` is 0, and `allDone` and `errFlag` are 0.
- R2: With `enStrapN` high a start request is ignored: no request pulse, no flash read, no byte, and `allDone`/`errFlag` keep their values.
- R3: A target whose `tgtEnN` bit is 1 receives no request pulse and no bytes. The other target is still loaded.
- R4: Target 0 is loaded before target 1. For target i the loader reads word addresses (byte address >> 1) from the image's first byte through its last byte inclusive, in ascending order, and streams every word without stopping early.
- R5: Each word is sent as bits 7:0 first, then bits 15:8. A byte is placed on `cfgData` while `cfgClk` is low and is held unchanged while `cfgClk` is high. The target takes it on the rising edge.
- R6: `flashRdN` is held low with a stable address for RD_WAIT clock cycles before the word is captured.
- R7: Each load starts with `cfgReqN[i]` low for exactly REQ_CYC cycles. No byte is clocked to a target while its `tgtStatus` bit is low.
- R8: If `tgtStatus[i]` falls during streaming or during the wait for done, no further byte goes to target i and `errFlag[i]` is set. The loader then continues with the next target.
- R9: No word inside the option region (OPT_BASE up to OPT_BASE+OPT_SIZE-1, byte addresses) is ever read. Reaching it aborts that load with `errFlag[i]` set.
- R10: A load is complete only once `tgtDone[i]` is high. `allDone` rises at the end of a pass with no error set, is cleared when a pass starts, and holds while idle.
- R11: At most one `cfgReqN` bit is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enStrapN | input | 1 | Active-low loader enable strap |
| startReq | input | 1 | Start a new pass while idle |
| tgtEnN | input | 2 | Active-low per-target load enable |
| flashAddr | output | FLASH_AW | Flash word address |
| flashRdN | output | 1 | Active-low flash read strobe |
| flashData | input | 16 | Flash read data |
| cfgClk | output | 1 | Configuration clock |
| cfgData | output | 8 | Configuration data byte |
| cfgReqN | output | 2 | Active-low per-target configuration request |
| tgtStatus | input | 2 | Per-target status, high = ready |
| tgtDone | input | 2 | Per-target configuration done |
| errFlag | output | 2 | Per-target load error |
| allDone | output | 1 | Pass finished with no error |

## Verification
The flash model returns a poison word unless the strobe has been low on the same address for RD_WAIT cycles. A loader that samples one cycle early therefore streams wrong bytes, and a loader that swaps byte order or skips the last word fails the ordered scoreboard. The target model kills its status right after the third byte. A loader that ignores this would push a fourth byte or raise the combined done. The done input is delayed after the last byte, so a loader that finishes on the last byte would raise `allDone` too early. A second instance has an image that runs into the option region, and it must stop after exactly the words below that region.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_PICK, ST_REQ, ST_WSTAT, ST_FETCH, ST_LOSET,
    ST_LOCLK, ST_HISET, ST_HICLK, ST_WDONE, ST_NEXT, ST_FIN
  } ldState_t;

  typedef struct packed {
    logic tgt;
    logic loadAddr;
    logic fetch;
    logic putLo;
    logic putHi;
    logic clkHi;
    logic advance;
  } ldStrobe_t;
endpackage

// File: rtl/cfgld_datapath.sv
module cfgld_datapath
  import cfgld_pkg::*;
#(
  parameter int          FLASH_AW  = 26,
  parameter logic [31:0] IMG0_BASE = 32'h0002_0000,
  parameter logic [31:0] IMG0_LAST = 32'h0209_FFFF,
  parameter logic [31:0] IMG1_BASE = 32'h020A_0000,
  parameter logic [31:0] IMG1_LAST = 32'h040F_FFFF,
  parameter logic [31:0] OPT_BASE  = 32'h0001_8000,
  parameter logic [31:0] OPT_SIZE  = 32'h0000_2000,
  parameter int          RD_WAIT   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ldStrobe_t           stb,
  input  logic [15:0]         flashData,
  output logic [FLASH_AW-1:0] flashAddr,
  output logic                flashRdN,
  output logic [7:0]          cfgData,
  output logic                cfgClk,
  output logic                waitDone,
  output logic                lastWord,
  output logic                optHit
);
  localparam int WAIT_W = $clog2(RD_WAIT + 1);
  localparam logic [31:0] OPT_END = OPT_BASE + OPT_SIZE - 32'd1;
  localparam logic [FLASH_AW-1:0] W0_BASE  = IMG0_BASE[FLASH_AW:1];
  localparam logic [FLASH_AW-1:0] W0_LAST  = IMG0_LAST[FLASH_AW:1];
  localparam logic [FLASH_AW-1:0] W1_BASE  = IMG1_BASE[FLASH_AW:1];
  localparam logic [FLASH_AW-1:0] W1_LAST  = IMG1_LAST[FLASH_AW:1];
  localparam logic [FLASH_AW-1:0] OPT_W_LO = OPT_BASE[FLASH_AW:1];
  localparam logic [FLASH_AW-1:0] OPT_W_HI = OPT_END[FLASH_AW:1];

  logic [FLASH_AW-1:0] addr;
  logic [15:0]         wordReg;
  logic [WAIT_W-1:0]   waitCnt;
  logic                tgtReg;
  logic                readActive;
  logic [FLASH_AW-1:0] curBase, curLast;

  assign curBase    = tgtReg ? W1_BASE : W0_BASE;
  assign curLast    = tgtReg ? W1_LAST : W0_LAST;
  assign optHit     = (addr >= OPT_W_LO) && (addr <= OPT_W_HI);
  assign readActive = stb.fetch && !optHit;
  assign waitDone   = (waitCnt == WAIT_W'(RD_WAIT - 1));
  assign lastWord   = (addr == curLast);
  assign flashAddr  = addr;
  assign flashRdN   = !readActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr    <= '0;
      wordReg <= '0;
      waitCnt <= '0;
      tgtReg  <= 1'b0;
      cfgData <= '0;
      cfgClk  <= 1'b0;
    end else begin
      cfgClk <= stb.clkHi;
      if (stb.loadAddr) begin
        addr   <= stb.tgt ? W1_BASE : W0_BASE;
        tgtReg <= stb.tgt;
      end else if (stb.advance) begin
        addr <= addr + 1'b1;
      end
      if (readActive) waitCnt <= waitCnt + 1'b1;
      else            waitCnt <= '0;
      if (readActive && waitDone) wordReg <= flashData;
      if (stb.putLo) cfgData <= wordReg[7:0];
      if (stb.putHi) cfgData <= wordReg[15:8];
    end
  end

  // R4
  rd_in_image_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flashRdN |-> (flashAddr >= curBase && flashAddr <= curLast));

  // R5
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgClk |-> $stable(cfgData));
endmodule

// File: rtl/cfgld_control.sv
module cfgld_control
  import cfgld_pkg::*;
#(
  parameter int REQ_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enStrapN,
  input  logic       startReq,
  input  logic [1:0] tgtEnN,
  input  logic [1:0] tgtStatus,
  input  logic [1:0] tgtDone,
  input  logic       waitDone,
  input  logic       lastWord,
  input  logic       optHit,
  output ldStrobe_t  stb,
  output logic [1:0] cfgReqN,
  output logic [1:0] errFlag,
  output logic       allDone
);
  localparam int REQ_W = $clog2(REQ_CYC + 1);

  ldState_t         st, nxt;
  logic             cur;
  logic [REQ_W-1:0] reqCnt;
  logic             streaming, abortNow;

  assign streaming = (st == ST_FETCH) || (st == ST_LOSET) || (st == ST_LOCLK) ||
                     (st == ST_HISET) || (st == ST_HICLK) || (st == ST_WDONE);
  assign abortNow  = (streaming && !tgtStatus[cur]) || ((st == ST_FETCH) && optHit);

  always_comb begin
    nxt = st;
    stb = '0;
    stb.tgt = cur;
    case (st)
      ST_IDLE:  if (startReq) nxt = ST_START;
      ST_START: nxt = enStrapN ? ST_IDLE : ST_PICK;
      ST_PICK: begin
        if (!tgtEnN[cur]) begin
          stb.loadAddr = 1'b1;
          nxt = ST_REQ;
        end else begin
          nxt = ST_NEXT;
        end
      end
      ST_REQ:   if (reqCnt == REQ_W'(REQ_CYC - 1)) nxt = ST_WSTAT;
      ST_WSTAT: if (tgtStatus[cur]) nxt = ST_FETCH;
      ST_FETCH: begin
        stb.fetch = 1'b1;
        if (waitDone) nxt = ST_LOSET;
      end
      ST_LOSET: begin stb.putLo = 1'b1; nxt = ST_LOCLK; end
      ST_LOCLK: begin stb.clkHi = 1'b1; nxt = ST_HISET; end
      ST_HISET: begin stb.putHi = 1'b1; nxt = ST_HICLK; end
      ST_HICLK: begin
        stb.clkHi = 1'b1;
        if (lastWord) nxt = ST_WDONE;
        else begin
          stb.advance = 1'b1;
          nxt = ST_FETCH;
        end
      end
      ST_WDONE: if (tgtDone[cur]) nxt = ST_NEXT;
      ST_NEXT:  nxt = cur ? ST_FIN : ST_PICK;
      ST_FIN:   nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    if (abortNow) begin
      stb = '0;
      stb.tgt = cur;
      nxt = ST_NEXT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_START;
      cur     <= 1'b0;
      reqCnt  <= '0;
      cfgReqN <= 2'b11;
      errFlag <= 2'b00;
      allDone <= 1'b0;
    end else begin
      st <= nxt;
      case (st)
        ST_START: if (nxt == ST_PICK) begin
          cur     <= 1'b0;
          errFlag <= 2'b00;
          allDone <= 1'b0;
        end
        ST_PICK: if (stb.loadAddr) begin
          cfgReqN[cur] <= 1'b0;
          reqCnt       <= '0;
        end
        ST_REQ: begin
          reqCnt <= reqCnt + 1'b1;
          if (nxt == ST_WSTAT) cfgReqN <= 2'b11;
        end
        ST_NEXT: if (!cur) cur <= 1'b1;
        ST_FIN:  allDone <= (errFlag == 2'b00);
        default: ;
      endcase
      if (abortNow) errFlag[cur] <= 1'b1;
    end
  end

  // R11
  one_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~cfgReqN));

  // R10
  done_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    allDone |-> (errFlag == 2'b00));
endmodule

// File: rtl/dual_cfg_loader.sv
module dual_cfg_loader
  import cfgld_pkg::*;
#(
  parameter int          FLASH_AW  = 26,
  parameter logic [31:0] IMG0_BASE = 32'h0002_0000,
  parameter logic [31:0] IMG0_LAST = 32'h0209_FFFF,
  parameter logic [31:0] IMG1_BASE = 32'h020A_0000,
  parameter logic [31:0] IMG1_LAST = 32'h040F_FFFF,
  parameter logic [31:0] OPT_BASE  = 32'h0001_8000,
  parameter logic [31:0] OPT_SIZE  = 32'h0000_2000,
  parameter int          RD_WAIT   = 4,
  parameter int          REQ_CYC   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enStrapN,
  input  logic                startReq,
  input  logic [1:0]          tgtEnN,
  output logic [FLASH_AW-1:0] flashAddr,
  output logic                flashRdN,
  input  logic [15:0]         flashData,
  output logic                cfgClk,
  output logic [7:0]          cfgData,
  output logic [1:0]          cfgReqN,
  input  logic [1:0]          tgtStatus,
  input  logic [1:0]          tgtDone,
  output logic [1:0]          errFlag,
  output logic                allDone
);
  ldStrobe_t stb;
  logic      waitDone, lastWord, optHit;

  cfgld_control #(.REQ_CYC(REQ_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .enStrapN(enStrapN), .startReq(startReq),
    .tgtEnN(tgtEnN), .tgtStatus(tgtStatus), .tgtDone(tgtDone),
    .waitDone(waitDone), .lastWord(lastWord), .optHit(optHit),
    .stb(stb), .cfgReqN(cfgReqN), .errFlag(errFlag), .allDone(allDone)
  );

  cfgld_datapath #(
    .FLASH_AW(FLASH_AW), .IMG0_BASE(IMG0_BASE), .IMG0_LAST(IMG0_LAST),
    .IMG1_BASE(IMG1_BASE), .IMG1_LAST(IMG1_LAST), .OPT_BASE(OPT_BASE),
    .OPT_SIZE(OPT_SIZE), .RD_WAIT(RD_WAIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .flashData(flashData),
    .flashAddr(flashAddr), .flashRdN(flashRdN), .cfgData(cfgData),
    .cfgClk(cfgClk), .waitDone(waitDone), .lastWord(lastWord), .optHit(optHit)
  );
endmodule

// File: tb/sim_dual_cfg_loader.sv
module sim_dual_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 26;
  localparam int RD_W = 3;
  localparam int REQ_N = 4;
  localparam int DONE_LAG = 30;
  localparam logic [31:0] I0B = 32'h0002_0000, I0L = 32'h0002_0007;
  localparam logic [31:0] I1B = 32'h020A_0000, I1L = 32'h020A_000B;
  localparam logic [31:0] G0B = 32'h0001_7FFC, G0L = 32'h0001_8007;

  logic clk = 0, rstN = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;

  logic          enStrapN, startReq;
  logic [1:0]    tgtEnN, cfgReqN, errFlag, tStat, tDone;
  logic [AW-1:0] flashAddr;
  logic          flashRdN, cfgClk, allDone;
  logic [15:0]   flashData;
  logic [7:0]    cfgData;

  logic [AW-1:0] g1Addr;
  logic          g1RdN, g1Clk, g1Done;
  logic [7:0]    g1Data;
  logic [1:0]    g1ReqN, g1Err;

  function automatic logic [15:0] flashWord(input logic [AW-1:0] a);
    return {a[7:0] ^ a[23:16] ^ 8'h5C, a[7:0] + a[20:13] + 8'h31};
  endfunction

  dual_cfg_loader #(.FLASH_AW(AW), .IMG0_BASE(I0B), .IMG0_LAST(I0L),
    .IMG1_BASE(I1B), .IMG1_LAST(I1L), .RD_WAIT(RD_W), .REQ_CYC(REQ_N)) u0 (
    .clk(clk), .rstN(rstN), .enStrapN(enStrapN), .startReq(startReq),
    .tgtEnN(tgtEnN), .flashAddr(flashAddr), .flashRdN(flashRdN),
    .flashData(flashData), .cfgClk(cfgClk), .cfgData(cfgData),
    .cfgReqN(cfgReqN), .tgtStatus(tStat), .tgtDone(tDone),
    .errFlag(errFlag), .allDone(allDone));

  dual_cfg_loader #(.FLASH_AW(AW), .IMG0_BASE(G0B), .IMG0_LAST(G0L),
    .IMG1_BASE(I1B), .IMG1_LAST(I1L), .RD_WAIT(RD_W), .REQ_CYC(REQ_N)) u1 (
    .clk(clk), .rstN(rstN), .enStrapN(1'b0), .startReq(1'b0),
    .tgtEnN(2'b10), .flashAddr(g1Addr), .flashRdN(g1RdN),
    .flashData(flashWord(g1Addr)), .cfgClk(g1Clk), .cfgData(g1Data),
    .cfgReqN(g1ReqN), .tgtStatus(2'b11), .tgtDone(2'b11),
    .errFlag(g1Err), .allDone(g1Done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [8:0] expQ[$];
  task automatic pushImage(input bit tgt, input logic [31:0] b, input logic [31:0] l, input int limit);
    int n = 0;
    for (logic [AW-1:0] a = b[AW:1]; a <= l[AW:1]; a++) begin
      logic [15:0] w = flashWord(a);
      if (n < limit) begin expQ.push_back({tgt, w[7:0]}); n++; end
      if (n < limit) begin expQ.push_back({tgt, w[15:8]}); n++; end
    end
  endtask

  // flash model with access latency, target models and byte monitor
  int age = -1;
  logic [AW-1:0] lastAddr = '0;
  int rx[2], relCnt[2], reqLen[2], doneCnt[2], killAt[2], expBytes[2];
  bit killed[2], reqSeen[2];
  bit actTgt = 0, prevClk = 0, g1Prev = 0;
  int byteTotal = 0, readCyc = 0, g1Cnt = 0, g1BadRd = 0;
  logic [7:0] g1Bytes[8];

  initial begin
    flashData = 16'hDEAD; tStat = 2'b00; tDone = 2'b00;
    for (int i = 0; i < 2; i++) begin
      rx[i] = 0; relCnt[i] = 0; reqLen[i] = 0; doneCnt[i] = 0;
      killAt[i] = -1; killed[i] = 0; reqSeen[i] = 0;
    end
    expBytes[0] = 8; expBytes[1] = 12;
  end

  always @(negedge clk) begin
    if (rstN) begin
      // R11: one request at a time
      if (cfgReqN == 2'b00) chk(0, "R11 both requests low", cfgReqN, 2'b01);
      if (!flashRdN) readCyc++;
      if (cfgClk && !prevClk) begin
        logic [8:0] e;
        byteTotal++;
        // R7: no byte while status low
        if (!tStat[actTgt]) chk(0, "R7 byte with status low", 0, 1);
        if (expQ.size() == 0) chk(0, "R4 unexpected byte", {actTgt, cfgData}, 0);
        else begin
          e = expQ.pop_front();
          chk(e == {actTgt, cfgData}, "R4/R5/R6 byte", {actTgt, cfgData}, e);
        end
        rx[actTgt]++;
        if (rx[actTgt] == killAt[actTgt]) begin tStat[actTgt] = 1'b0; killed[actTgt] = 1; end
      end
      prevClk = cfgClk;
      for (int i = 0; i < 2; i++) begin
        if (!cfgReqN[i]) begin
          tStat[i] = 1'b0; tDone[i] = 1'b0; rx[i] = 0; relCnt[i] = 0;
          doneCnt[i] = 0; killed[i] = 0; reqSeen[i] = 1; actTgt = i[0];
          reqLen[i]++;
        end else begin
          if (reqLen[i] != 0) begin
            chk(reqLen[i] == REQ_N, "R7 request pulse length", reqLen[i], REQ_N);
            reqLen[i] = 0;
          end
          if (!tStat[i] && !killed[i]) begin
            relCnt[i]++;
            if (relCnt[i] >= 3) tStat[i] = 1'b1;
          end
          if (rx[i] == expBytes[i] && !tDone[i]) begin
            doneCnt[i]++;
            if (doneCnt[i] >= DONE_LAG) tDone[i] = 1'b1;
          end
        end
      end
      // R9 guard instance
      if (!g1RdN && g1Addr >= 26'h000C000 && g1Addr <= 26'h000CFFF) g1BadRd++;
      if (g1Clk && !g1Prev) begin
        if (g1Cnt < 8) g1Bytes[g1Cnt] = g1Data;
        g1Cnt++;
      end
      g1Prev = g1Clk;
    end
    // R6: data is only valid after RD_W cycles on a stable address
    if (flashRdN) age = -1;
    else if (flashAddr != lastAddr || age < 0) age = 0;
    else if (age < 1000) age++;
    lastAddr = flashAddr;
    flashData = (!flashRdN && age >= RD_W - 1) ? flashWord(flashAddr) : 16'hDEAD;
  end

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  initial begin
    enStrapN = 1'b0; startReq = 1'b0; tgtEnN = 2'b00;
    pushImage(0, I0B, I0L, 99);
    pushImage(1, I1B, I1L, 99);
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(cfgReqN == 2'b11, "R1 reset cfgReqN", cfgReqN, 3);
    chk(flashRdN == 1'b1, "R1 reset flashRdN", flashRdN, 1);
    chk(cfgClk == 1'b0, "R1 reset cfgClk", cfgClk, 0);
    chk(allDone == 1'b0 && errFlag == 2'b00, "R1 reset flags", {allDone, errFlag}, 0);
    rstN = 1'b1;

    // pass 1: automatic start, both targets
    for (int k = 0; k < 3000 && rx[1] < 12; k++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(allDone == 1'b0, "R10 done before target done", allDone, 0);
    repeat (60) @(negedge clk);
    chk(reqSeen[0] && reqSeen[1], "R1 auto start", {reqSeen[1], reqSeen[0]}, 3);
    chk(allDone == 1'b1, "R10 allDone after clean pass", allDone, 1);
    chk(errFlag == 2'b00, "R8 no error", errFlag, 0);
    chk(expQ.size() == 0, "R4 all bytes streamed", expQ.size(), 0);
    // R9 guard instance: stops right below the option region
    chk(g1Cnt == 4, "R9 bytes before option region", g1Cnt, 4);
    chk(g1Err == 2'b01 && g1Done == 1'b0, "R9 abort flags", {g1Done, g1Err}, 1);
    chk(g1BadRd == 0, "R9 read inside option region", g1BadRd, 0);
    begin
      logic [15:0] w0 = flashWord(26'h000BFFE), w1 = flashWord(26'h000BFFF);
      chk({g1Bytes[3], g1Bytes[2], g1Bytes[1], g1Bytes[0]} == {w1, w0},
          "R9 guarded bytes", {g1Bytes[3], g1Bytes[2], g1Bytes[1], g1Bytes[0]}, {w1, w0});
    end

    // pass 2: target 0 disabled
    tgtEnN = 2'b01; reqSeen[0] = 0; reqSeen[1] = 0;
    pushImage(1, I1B, I1L, 99);
    pulseStart();
    repeat (300) @(negedge clk);
    chk(reqSeen[0] == 0, "R3 disabled target requested", reqSeen[0], 0);
    chk(reqSeen[1] == 1, "R3 enabled target loaded", reqSeen[1], 1);
    chk(expQ.size() == 0, "R3 target 1 bytes", expQ.size(), 0);
    chk(allDone == 1'b1, "R10 allDone single target", allDone, 1);

    // strap high: start ignored
    enStrapN = 1'b1; tgtEnN = 2'b00; reqSeen[0] = 0; reqSeen[1] = 0;
    byteTotal = 0; readCyc = 0;
    pulseStart();
    repeat (200) @(negedge clk);
    chk(!reqSeen[0] && !reqSeen[1], "R2 request with strap high", {reqSeen[1], reqSeen[0]}, 0);
    chk(byteTotal == 0 && readCyc == 0, "R2 activity with strap high", byteTotal + readCyc, 0);
    chk(allDone == 1'b1 && errFlag == 2'b00, "R2 flags kept", {allDone, errFlag}, 4);

    // pass 3: target 0 drops status after 3 bytes
    enStrapN = 1'b0; killAt[0] = 3;
    pushImage(0, I0B, I0L, 3);
    pushImage(1, I1B, I1L, 99);
    pulseStart();
    repeat (3) @(negedge clk);
    chk(allDone == 1'b0, "R10 allDone cleared at start", allDone, 0);
    repeat (500) @(negedge clk);
    chk(errFlag == 2'b01, "R8 error flag", errFlag, 1);
    chk(rx[1] == 12, "R8 next target still loaded", rx[1], 12);
    chk(expQ.size() == 0, "R8 bytes after abort", expQ.size(), 0);
    chk(allDone == 1'b0, "R10 allDone with error", allDone, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule